// File: doc/BRIEF.md
# Precharge Gate-Override Stage for a Four-Level Flying-Capacitor Leg

This block sits between the phase-shifted PWM comparators and the dead-time stage of one flying-capacitor leg with three switch positions. In normal operation it passes the three complementary PWM pairs to the six gate commands with one cycle of latency. It also makes sure the upper and lower gates of a pair are never on together. A supervising processor can take over the leg for capacitor precharge. It raises the precharge enable and selects a step code. The block then ignores the PWM inputs and drives a fixed gate pattern for that step.

In precharge the inner capacitor is charged first. Pairs 0 (outermost position) and 1 are turned fully on, with both gates of each pair on. When that capacitor reaches a third of the DC-link voltage, the processor selects the second step. In that step only pair 0 stays fully on, and this charges the outer capacitor. Only in precharge may both gates of a pair be on together. Dead-time is added downstream, not here.

Mode and step changes are registered. Any change to the effective configuration causes one full cycle with every gate off before the new behaviour starts.

Top module: `pchg_gate_override`

## Requirements
- R1: While reset is asserted (active low) and in the first cycle after it, all six gate outputs are 0. The block starts in normal mode.
- R2: In normal mode, with the configuration unchanged, each gate output equals its PWM input as sampled at the previous rising clock edge, provided the pair's two inputs are not both high.
- R3: In normal mode, a pair whose two PWM inputs are both high produces both gate outputs 0. Outside precharge, no pair ever has both gates on.
- R4: With precharge enabled and step code 2'b01 (charge inner capacitor), pairs 0 and 1 drive both gates high and pair 2 drives both gates low, whatever the PWM inputs.
- R5: With precharge enabled and step code 2'b10 (charge outer capacitor), only pair 0 drives both gates high, and every other gate is low, whatever the PWM inputs.
- R6: With precharge enabled and step code 2'b00, all gates are low.
- R7: With precharge enabled and step code 2'b11 (reserved), all gates are low.
- R8: The effective configuration is the enable together with the step, where the step counts as 2'b00 when precharge is disabled. When the effective configuration sampled at an edge differs from the one held before that edge, all gates are 0 for the following cycle. The new behaviour appears one edge later.
- R9: While precharge is disabled, changes on the step input cause no blanking and do not disturb the pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_hi | input | 3 | Upper PWM command per pair, bit 0 = outermost |
| pwm_lo | input | 3 | Lower (complementary) PWM command per pair |
| pchg_en | input | 1 | 1 selects precharge override |
| pchg_step | input | 2 | Precharge step code |
| gate_hi | output | 3 | Upper gate command per pair |
| gate_lo | output | 3 | Lower gate command per pair |

## Verification
If the held configuration goes wrong, it shows at the ports on the next edge in one of two ways. The leg keeps passing PWM when it should be forced, or it shows a pattern for the wrong step. A missing or doubled blanking cycle shows up as a gate that is on or off one cycle from where the model expects it, right at a mode or step change. A fault in the interlock shows as both gates of a pair on in normal mode, one cycle after both inputs were high. The bench compares every cycle, so each of these faults is reported within one clock of the stimulus that exposes it.

// File: rtl/pchg_pkg.sv
package pchg_pkg;

    typedef enum logic [1:0] {
        STEP_OFF = 2'b00,
        STEP_C2  = 2'b01,
        STEP_C1  = 2'b10,
        STEP_RSV = 2'b11
    } step_e;

    typedef struct packed {
        logic  en;
        step_e step;
    } cfg_t;

    localparam cfg_t CFG_IDLE = '{en: 1'b0, step: STEP_OFF};

endpackage

// File: rtl/pair_interlock.sv
module pair_interlock (
    input  logic a_in,
    input  logic b_in,
    output logic a_out,
    output logic b_out
);
    always_comb begin
        a_out = a_in & ~b_in;
        b_out = b_in & ~a_in;
    end

    always_comb begin
        // R3
        excl_chk: assert (!(a_out && b_out));
    end
endmodule

// File: rtl/pchg_pattern.sv
module pchg_pattern
    import pchg_pkg::*;
#(
    parameter int NPAIRS = 3,
    parameter logic [NPAIRS-1:0] C2_MASK = 3'b011,
    parameter logic [NPAIRS-1:0] C1_MASK = 3'b001
) (
    input  step_e             step,
    output logic [NPAIRS-1:0] pat_hi,
    output logic [NPAIRS-1:0] pat_lo
);
    always_comb begin
        unique case (step)
            STEP_C2: pat_hi = C2_MASK;
            STEP_C1: pat_hi = C1_MASK;
            default: pat_hi = '0;
        endcase
        pat_lo = pat_hi;
    end

    always_comb begin
        // R7
        rsv_off_chk: assert (step != STEP_RSV || pat_hi == '0);
    end
endmodule

// File: rtl/pchg_gate_override.sv
module pchg_gate_override
    import pchg_pkg::*;
#(
    parameter int NPAIRS = 3,
    parameter logic [NPAIRS-1:0] C2_MASK = 3'b011,
    parameter logic [NPAIRS-1:0] C1_MASK = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAIRS-1:0] pwm_hi,
    input  logic [NPAIRS-1:0] pwm_lo,
    input  logic              pchg_en,
    input  logic [1:0]        pchg_step,
    output logic [NPAIRS-1:0] gate_hi,
    output logic [NPAIRS-1:0] gate_lo
);
    typedef struct packed {
        cfg_t              cfg;
        logic [NPAIRS-1:0] hi;
        logic [NPAIRS-1:0] lo;
    } state_t;

    state_t cur_q, nxt_d;
    cfg_t   cfg_in;
    logic [NPAIRS-1:0] ilk_hi, ilk_lo, pat_hi, pat_lo;

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        pair_interlock u_ilk (
            .a_in  (pwm_hi[p]),
            .b_in  (pwm_lo[p]),
            .a_out (ilk_hi[p]),
            .b_out (ilk_lo[p])
        );
    end

    pchg_pattern #(
        .NPAIRS  (NPAIRS),
        .C2_MASK (C2_MASK),
        .C1_MASK (C1_MASK)
    ) u_pat (
        .step   (cur_q.cfg.step),
        .pat_hi (pat_hi),
        .pat_lo (pat_lo)
    );

    always_comb begin
        cfg_in.en   = pchg_en;
        cfg_in.step = pchg_en ? step_e'(pchg_step) : STEP_OFF;
        nxt_d       = cur_q;
        nxt_d.cfg   = cfg_in;
        if (cfg_in != cur_q.cfg) begin
            nxt_d.hi = '0;
            nxt_d.lo = '0;
        end else if (cur_q.cfg.en) begin
            nxt_d.hi = pat_hi;
            nxt_d.lo = pat_lo;
        end else begin
            nxt_d.hi = ilk_hi;
            nxt_d.lo = ilk_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cfg: CFG_IDLE, hi: '0, lo: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign gate_hi = cur_q.hi;
    assign gate_lo = cur_q.lo;

    // R3
    no_shoot_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & gate_lo) != '0) |-> cur_q.cfg.en);

    // R8
    blank_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cfg != $past(cur_q.cfg)) |-> (gate_hi == '0 && gate_lo == '0));

    // R6
    idle_step_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cfg.en && cur_q.cfg.step == STEP_OFF) |-> (gate_hi == '0 && gate_lo == '0));

    // R5
    c1_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cfg.en && cur_q.cfg.step == STEP_C1) |-> ((gate_hi & ~C1_MASK) == '0));

    // R4
    c2_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cfg.en && cur_q.cfg.step == STEP_C2) |-> ((gate_lo & ~C2_MASK) == '0));
endmodule

// File: tb/sim_pchg_gate_override.sv
module sim_pchg_gate_override;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pwm_hi = '0, pwm_lo = '0;
    logic       pchg_en = 1'b0;
    logic [1:0] pchg_step = '0;
    logic [2:0] gate_hi, gate_lo;

    int n_chk = 0, n_bad = 0;
    logic [2:0] prev_eff = 3'b000;
    bit done = 0;

    always #10 clk = ~clk;

    pchg_gate_override u0 (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .pchg_en(pchg_en), .pchg_step(pchg_step),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    function automatic logic [2:0] eff_of(input logic en, input logic [1:0] st);
        return en ? {1'b1, st} : 3'b000;
    endfunction

    function automatic logic [5:0] expect_of(input logic [2:0] eff, input logic [2:0] prev,
                                             input logic [2:0] ph, input logic [2:0] pl);
        if (eff != prev) return 6'b0;
        if (!eff[2]) return {ph & ~pl, pl & ~ph};
        case (eff[1:0])
            2'b01:   return {3'b011, 3'b011};
            2'b10:   return {3'b001, 3'b001};
            default: return 6'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] eff, input logic [2:0] prev,
                                     input logic [2:0] ph, input logic [2:0] pl);
        if (eff != prev) return "R8";
        if (!eff[2]) return ((ph & pl) != 0) ? "R3" : "R2";
        case (eff[1:0])
            2'b01:   return "R4";
            2'b10:   return "R5";
            2'b00:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [5:0] exp);
        n_chk++;
        if ({gate_hi, gate_lo} !== exp) begin
            n_bad++;
            $display("FAIL %s got hi=%b lo=%b expected hi=%b lo=%b",
                     tag, gate_hi, gate_lo, exp[5:3], exp[2:0]);
        end
    endtask

    task automatic cyc(input logic en, input logic [1:0] st,
                       input logic [2:0] ph, input logic [2:0] pl, input string force_tag);
        logic [2:0] e;
        @(negedge clk);
        pchg_en = en; pchg_step = st; pwm_hi = ph; pwm_lo = pl;
        @(posedge clk); #1;
        e = eff_of(en, st);
        check(force_tag != "" ? force_tag : tag_of(e, prev_eff, ph, pl),
              expect_of(e, prev_eff, ph, pl));
        prev_eff = e;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: outputs off during reset even with PWM active
        pwm_hi = 3'b101; pwm_lo = 3'b010;
        repeat (3) @(posedge clk);
        #1 check("R1", 6'b0);
        @(negedge clk); rst_n = 1'b1;
        // R2 / R3 directed
        cyc(0, 2'b00, 3'b101, 3'b010, "R2");
        cyc(0, 2'b00, 3'b111, 3'b111, "R3");
        cyc(0, 2'b00, 3'b010, 3'b110, "");
        // R9: step wiggles while disabled
        cyc(0, 2'b11, 3'b001, 3'b110, "R9");
        cyc(0, 2'b01, 3'b100, 3'b011, "R9");
        // R8 + R4
        cyc(1, 2'b01, 3'b000, 3'b111, "R8");
        cyc(1, 2'b01, 3'b000, 3'b111, "R4");
        cyc(1, 2'b01, 3'b101, 3'b010, "R4");
        // R5
        cyc(1, 2'b10, 3'b111, 3'b000, "R8");
        cyc(1, 2'b10, 3'b111, 3'b000, "R5");
        // R7
        cyc(1, 2'b11, 3'b011, 3'b011, "R8");
        cyc(1, 2'b11, 3'b011, 3'b011, "R7");
        // R6
        cyc(1, 2'b00, 3'b011, 3'b100, "R8");
        cyc(1, 2'b00, 3'b011, 3'b100, "R6");
        // back to normal
        cyc(0, 2'b10, 3'b110, 3'b001, "R8");
        cyc(0, 2'b10, 3'b110, 3'b001, "R2");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic en_r;
            logic [1:0] st_r;
            en_r = ($urandom_range(0, 9) < 3) ? ~pchg_en : pchg_en;
            st_r = ($urandom_range(0, 9) < 2) ? 2'($urandom) : pchg_step;
            cyc(en_r, st_r, 3'($urandom), 3'($urandom), "");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule